// File: doc/BRIEF.md
# Doppler-Shifted Clock Oscillator

This block generates a square-wave clock near 1 MHz from a fast system clock. A phase accumulator adds a phase increment on every system clock, and its top bit is the output clock. The increment is a fixed base word for the nominal frequency plus a small signed Doppler offset. This lets the output frequency be moved by a few hertz either side of nominal, in steps of a few hundredths of a hertz.

The caller supplies a requested offset and a ramp-rate value. The applied offset does not jump to the requested value. It moves one code at a time toward it, with one step every N system clocks, and it stops exactly on the request. A request outside the legal window is limited to the window edge before it is used. The block also gives a one-clock strobe on every rising edge of the generated clock, and it reports the offset currently applied.

With the default parameters (32-bit phase at a 100 MHz system clock) one offset code is about 0.0233 Hz. The base word is 42949673 and the window is ±214 codes, which is about ±5 Hz.

Top module: `dopp_clk_nco`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the phase is zero: `nco_clk_o` is 0, `rise_o` is 0 and `offset_o` is 0.
- R2: On every system clock edge out of reset, the 32-bit phase advances by BASE_WORD (42949673) plus the sign-extended applied offset, modulo 2^32. `nco_clk_o` is phase bit 31. The new offset value is first used on the edge after the one that stored it.
- R3: `rise_o` is 1 for exactly the cycles in which `nco_clk_o` is 1 and was 0 in the previous cycle. It is never high in two consecutive cycles.
- R4: When the applied offset differs from the limited target, the offset moves by exactly one code toward the target. The step happens on the N-th clock edge after the step counter was last cleared, where N is `rate_i`. The counter is cleared on each step and on every cycle in which the offset already equals the target.
- R5: The target is limited to the range −214 to +214 codes before use. A request beyond that range drives the offset to the matching limit.
- R6: The applied offset never passes the target. Once equal to the target it stays constant, and its magnitude never exceeds 214.
- R7: A `rate_i` of 0 is treated as 1, which gives one step on every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| target_i | input | 16 | Requested Doppler offset in codes, two's complement |
| rate_i | input | 16 | Clock edges per offset step |
| nco_clk_o | output | 1 | Generated clock (phase MSB) |
| rise_o | output | 1 | One-cycle strobe on each rising edge of the generated clock |
| offset_o | output | 16 | Offset currently applied, two's complement |

## Verification
Two events can fall on the same clock edge: an offset step and a wrap of the phase into its upper half. On that edge the strobe must use the old increment, and the new step takes effect only on the following edge. With a step rate of one code per edge during long ramps, steps land on rising edges of the generated clock many times. A behavioural model in the bench, built on integer arithmetic, predicts the phase bit, the strobe and the offset for every cycle and compares them with the outputs. A second coincidence is a target reversal or a rate change part-way through a step count. The bench judges this by the exact cycle of the next step.

// File: rtl/dopp_nco_pkg.sv
package dopp_nco_pkg;
    localparam int DEF_PHASE_W  = 32;
    localparam int DEF_OFF_W    = 16;
    localparam int DEF_RATE_W   = 16;
    localparam int DEF_MAX_OFF  = 214;
    localparam logic [31:0] DEF_BASE_WORD = 32'd42949673;
endpackage

// File: rtl/dopp_target_limit.sv
module dopp_target_limit #(
    parameter int OFF_W   = dopp_nco_pkg::DEF_OFF_W,
    parameter int MAX_OFF = dopp_nco_pkg::DEF_MAX_OFF
) (
    input  logic signed [OFF_W-1:0] req_i,
    output logic signed [OFF_W-1:0] lim_o
);
    localparam logic signed [OFF_W-1:0] HI = OFF_W'(MAX_OFF);
    localparam logic signed [OFF_W-1:0] LO = -HI;

    always_comb begin
        if (req_i > HI) begin
            lim_o = HI;
        end else if (req_i < LO) begin
            lim_o = LO;
        end else begin
            lim_o = req_i;
        end
    end
endmodule

// File: rtl/dopp_offset_slew.sv
module dopp_offset_slew #(
    parameter int OFF_W   = dopp_nco_pkg::DEF_OFF_W,
    parameter int RATE_W  = dopp_nco_pkg::DEF_RATE_W,
    parameter int MAX_OFF = dopp_nco_pkg::DEF_MAX_OFF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [OFF_W-1:0] tgt_i,
    input  logic [RATE_W-1:0]       rate_i,
    output logic signed [OFF_W-1:0] off_o
);
    localparam logic signed [OFF_W-1:0] HI  = OFF_W'(MAX_OFF);
    localparam logic [OFF_W-1:0]        ONE = OFF_W'(1);

    typedef struct packed {
        logic [RATE_W-1:0] cnt;
        logic [OFF_W-1:0]  off;
    } slew_t;

    slew_t st_d, st_q;
    logic signed [OFF_W-1:0] off_q;
    logic [RATE_W-1:0]       lim;

    assign off_q = st_q.off;

    always_comb begin
        st_d = st_q;
        lim  = (rate_i == '0) ? '0 : rate_i - RATE_W'(1);
        if (off_q == tgt_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= lim) begin
            st_d.cnt = '0;
            st_d.off = (tgt_i > off_q) ? (st_q.off + ONE) : (st_q.off - ONE);
        end else begin
            st_d.cnt = st_q.cnt + RATE_W'(1);
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign off_o = off_q;

    // R4: the offset moves by at most one code per edge
    p_single_step_r4: assert property (@(posedge clk) disable iff (rst)
        (off_q != $past(off_q)) |-> ((off_q - $past(off_q) == 1) || ($past(off_q) - off_q == 1)));

    // R6: once on target the offset holds
    p_hold_on_target_r6: assert property (@(posedge clk) disable iff (rst)
        (off_q == tgt_i) |=> (off_q == $past(off_q)));

    // R6: the offset stays inside the legal window
    p_within_window_r6: assert property (@(posedge clk) disable iff (rst)
        (off_q <= HI) && (off_q >= -HI));

    // R5: the limiter never hands over a target beyond the window
    p_target_limited_r5: assert property (@(posedge clk) disable iff (rst)
        (tgt_i <= HI) && (tgt_i >= -HI));
endmodule

// File: rtl/dopp_phase_acc.sv
module dopp_phase_acc #(
    parameter int                 PHASE_W   = dopp_nco_pkg::DEF_PHASE_W,
    parameter int                 OFF_W     = dopp_nco_pkg::DEF_OFF_W,
    parameter logic [PHASE_W-1:0] BASE_WORD = PHASE_W'(dopp_nco_pkg::DEF_BASE_WORD)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [OFF_W-1:0] off_i,
    output logic                    msb_o,
    output logic                    rise_o
);
    localparam int EXT_W = PHASE_W - OFF_W;

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
        logic               rise;
    } acc_t;

    acc_t st_d, st_q;
    logic [PHASE_W-1:0] inc;

    always_comb begin
        inc       = BASE_WORD + {{EXT_W{off_i[OFF_W-1]}}, off_i};
        st_d      = st_q;
        st_d.acc  = st_q.acc + inc;
        st_d.rise = st_d.acc[PHASE_W-1] & ~st_q.acc[PHASE_W-1];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msb_o  = st_q.acc[PHASE_W-1];
    assign rise_o = st_q.rise;

    // R3: strobe never lasts two cycles
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

    // R3: strobe coincides with a high output clock
    p_strobe_on_high_r3: assert property (@(posedge clk) disable iff (rst)
        rise_o |-> msb_o);
endmodule

// File: rtl/dopp_clk_nco.sv
module dopp_clk_nco #(
    parameter int                 PHASE_W   = dopp_nco_pkg::DEF_PHASE_W,
    parameter int                 OFF_W     = dopp_nco_pkg::DEF_OFF_W,
    parameter int                 RATE_W    = dopp_nco_pkg::DEF_RATE_W,
    parameter int                 MAX_OFF   = dopp_nco_pkg::DEF_MAX_OFF,
    parameter logic [PHASE_W-1:0] BASE_WORD = PHASE_W'(dopp_nco_pkg::DEF_BASE_WORD)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [OFF_W-1:0] target_i,
    input  logic [RATE_W-1:0]       rate_i,
    output logic                    nco_clk_o,
    output logic                    rise_o,
    output logic signed [OFF_W-1:0] offset_o
);
    logic signed [OFF_W-1:0] tgt_lim;
    logic signed [OFF_W-1:0] off_cur;

    dopp_target_limit #(.OFF_W(OFF_W), .MAX_OFF(MAX_OFF)) u_limit (
        .req_i (target_i),
        .lim_o (tgt_lim)
    );

    dopp_offset_slew #(.OFF_W(OFF_W), .RATE_W(RATE_W), .MAX_OFF(MAX_OFF)) u_slew (
        .clk    (clk),
        .rst    (rst),
        .tgt_i  (tgt_lim),
        .rate_i (rate_i),
        .off_o  (off_cur)
    );

    dopp_phase_acc #(.PHASE_W(PHASE_W), .OFF_W(OFF_W), .BASE_WORD(BASE_WORD)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .off_i  (off_cur),
        .msb_o  (nco_clk_o),
        .rise_o (rise_o)
    );

    assign offset_o = off_cur;
endmodule

// File: tb/tb_dopp_clk_nco.sv
module tb_dopp_clk_nco;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [15:0] target = '0;
    logic [15:0]        rate = 16'd1;
    logic               nco_clk;
    logic               rise;
    logic signed [15:0] offset;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural model state
    longint m_acc = 0;
    int     m_off = 0;
    int     m_cnt = 0;
    bit     m_rise = 1'b0;

    always #10 clk = ~clk;

    dopp_clk_nco dut (
        .clk       (clk),
        .rst       (rst),
        .target_i  (target),
        .rate_i    (rate),
        .nco_clk_o (nco_clk),
        .rise_o    (rise),
        .offset_o  (offset)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // model update on every edge, from pre-edge state and stable inputs
    always @(posedge clk) begin
        if (rst) begin
            m_acc = 0; m_off = 0; m_cnt = 0; m_rise = 1'b0;
        end else begin
            longint nacc;
            int t, n, noff, ncnt;
            t = int'(target);
            if (t > 214) t = 214;
            if (t < -214) t = -214;
            n = (rate == 0) ? 1 : int'(rate);
            nacc = (m_acc + 64'd42949673 + longint'(m_off)) & 64'hFFFF_FFFF;
            noff = m_off;
            ncnt = m_cnt;
            if (m_off == t) begin
                ncnt = 0;
            end else if (m_cnt + 1 >= n) begin
                ncnt = 0;
                noff = (t > m_off) ? m_off + 1 : m_off - 1;
            end else begin
                ncnt = m_cnt + 1;
            end
            m_rise = nacc[31] && !m_acc[31];
            m_acc = nacc;
            m_off = noff;
            m_cnt = ncnt;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(nco_clk == m_acc[31], "R2 clk", nco_clk, m_acc[31]);
            chk(rise == m_rise, "R3 strobe", rise, m_rise);
            chk(int'(offset) == m_off, "R4 offset", offset, m_off);
            chk(offset <= 214 && offset >= -214, "R6 range", offset, 214);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int edges;
        wait_cyc(3);
        chk(nco_clk == 1'b0, "R1 clk in reset", nco_clk, 0);
        chk(rise == 1'b0, "R1 strobe in reset", rise, 0);
        chk(offset == 0, "R1 offset in reset", offset, 0);
        rst = 1'b0;
        wait_cyc(1);
        chk(offset == 0, "R1 offset after reset", offset, 0);

        // nominal: count strobes over 1000 cycles (~10 periods)
        edges = 0;
        for (int i = 0; i < 1000; i++) begin
            wait_cyc(1);
            if (rise) edges++;
        end
        chk(edges == 10, "R3 strobe count", edges, 10);

        // R5: large positive request saturates
        target = 16'sd1000; rate = 16'd1;
        wait_cyc(400);
        chk(offset == 214, "R5 positive limit", offset, 214);

        // R5: large negative request at rate 3
        target = -16'sd1000; rate = 16'd3;
        wait_cyc(1400);
        chk(offset == -214, "R5 negative limit", offset, -214);

        // R7: rate 0 behaves as 1
        target = 16'sd37; rate = 16'd0;
        wait_cyc(251);
        chk(offset == 37, "R7 rate zero arrival", offset, 37);
        wait_cyc(50);
        chk(offset == 37, "R6 hold on target", offset, 37);

        // reversal mid-ramp
        target = 16'sd100; rate = 16'd5;
        wait_cyc(100);
        chk(offset == 57, "R4 partial ramp", offset, 57);
        target = -16'sd20; rate = 16'd2;
        wait_cyc(300);
        chk(offset == -20, "R6 reversal lands", offset, -20);

        // R4: exact step timing with N=4 from a settled state
        target = -16'sd18; rate = 16'd4;
        wait_cyc(3);
        chk(offset == -20, "R4 before step", offset, -20);
        wait_cyc(1);
        chk(offset == -19, "R4 on step", offset, -19);
        wait_cyc(4);
        chk(offset == -18, "R4 second step", offset, -18);
        wait_cyc(20);
        chk(offset == -18, "R6 no overshoot", offset, -18);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule